// File: doc/BRIEF.md
# Vector Halving Reduction Unit

This block adds together every active element of a 2048-bit vector register and returns one scalar. It works by folding: in each step, the upper half of the active elements is lined up against the lower half and the two halves are added lane by lane. The active length is then halved, and the loop repeats until a single element is left. The element size is chosen by a two-bit width code. The number of elements the register can hold therefore ranges from 32 (64-bit elements) to 256 (8-bit elements).

A request is a one-cycle start pulse carrying the vector data, the width code and the number of elements to sum. Elements at or beyond that count are replaced by zeros before folding. The count is rounded up to the next power of two, so the fold always splits evenly. The number of fold steps is the base-2 logarithm of that rounded count. When the fold finishes, the sum is registered and a one-cycle done pulse is given. The sum stays in place until the next result is written.

Top module: `vred_halving_top`

## Requirements
- R1: During and right after synchronous reset, `sum_o` is 0 and `done_o` is 0.
- R2: Width code 0, 1, 2 and 3 select 8-, 16-, 32- and 64-bit elements. Element i sits at bits [i*E +: E] of `vec_i`, where E is the element width. The largest element count is 2048/E.
- R3: `sum_o` is the sum of elements 0 to n-1 modulo 2^E, zero-extended to 64 bits. Here n is the effective element count.
- R4: Elements at index n or above have no effect on the result.
- R5: A requested count above 2048/E is clamped to 2048/E.
- R6: A requested count of 0 gives a sum of 0.
- R7: Let s = ceil(log2(n)) for n >= 2, and s = 0 for n <= 1. Then `done_o` rises on the (s+1)-th rising edge after the edge that samples `start_i`.
- R8: `done_o` is high for exactly one cycle per request. `sum_o` changes only together with that pulse and holds its value otherwise.
- R9: A start pulse that arrives while a reduction is in progress is ignored. No extra done pulse follows, and the running result is not disturbed.
- R10: The width code, count and vector are captured at start. Later changes to those inputs have no effect on the request in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request pulse |
| width_i | input | 2 | Element width code |
| vlen_i | input | 9 | Requested element count |
| vec_i | input | 2048 | Vector register contents |
| sum_o | output | 64 | Scalar sum, zero-extended |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Each result is due at a fixed point: the sum and the done pulse both arrive s+1 rising edges after the edge that samples start. Here s is the fold step count worked out from the clamped and rounded length. The bench drives inputs on falling edges and counts falling edges from the start pulse. It expects done at count s+2 exactly, compares the sum in that same cycle, and checks that done has dropped one cycle later. For the ignored-start and held-result cases, it then watches a window of idle cycles in which neither output may change.

// File: rtl/vred_pkg.sv
package vred_pkg;
  localparam int unsigned LANE_BITS = 8;

  function automatic int unsigned elem_bits(input int unsigned code);
    return LANE_BITS << code;
  endfunction
endpackage

// File: rtl/vred_len.sv
module vred_len #(
  parameter int REG_BITS = 2048,
  parameter int CODE_W   = 2,
  localparam int NBYTES  = REG_BITS / 8,
  localparam int LEN_W   = $clog2(NBYTES) + 1
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [LEN_W-1:0]  vlen_i,
  output logic [LEN_W-1:0]  vl_eff_o,
  output logic [LEN_W-1:0]  len_pow_o
);
  logic [LEN_W-1:0] mvl;

  always_comb begin
    mvl      = LEN_W'(NBYTES) >> code_i;
    vl_eff_o = (vlen_i > mvl) ? mvl : vlen_i;
    len_pow_o = LEN_W'(1);
    for (int k = 0; k < LEN_W - 1; k++) begin
      if ((LEN_W'(1) << k) < vl_eff_o)
        len_pow_o = LEN_W'(1) << (k + 1);
    end
  end
endmodule

// File: rtl/vred_fold.sv
module vred_fold #(
  parameter int REG_BITS = 2048,
  parameter int CODE_W   = 2,
  localparam int NBYTES  = REG_BITS / 8,
  localparam int LEN_W   = $clog2(NBYTES) + 1,
  localparam int SHW     = $clog2(REG_BITS) + 1
) (
  input  logic [REG_BITS-1:0] work_i,
  input  logic [CODE_W-1:0]   code_i,
  input  logic [LEN_W-1:0]    half_i,
  output logic [REG_BITS-1:0] fold_o
);
  logic [SHW-1:0]      shamt;
  logic [REG_BITS-1:0] upper;
  int unsigned         lane_mask;

  always_comb begin
    shamt     = SHW'(half_i) << (3 + code_i);
    upper     = work_i >> shamt;
    lane_mask = (32'd1 << code_i) - 32'd1;
  end

  // segmented byte adder: carry is cut at each element boundary
  always_comb begin
    logic       carry;
    logic [8:0] part;
    carry  = 1'b0;
    fold_o = '0;
    for (int b = 0; b < NBYTES; b++) begin
      if ((b & lane_mask) == 0) carry = 1'b0;
      part = {1'b0, work_i[b*8 +: 8]} + {1'b0, upper[b*8 +: 8]} + {8'd0, carry};
      fold_o[b*8 +: 8] = part[7:0];
      carry = part[8];
    end
  end
endmodule

// File: rtl/vred_halving_top.sv
module vred_halving_top #(
  parameter int REG_BITS = 2048,
  parameter int CODE_W   = 2,
  localparam int NBYTES   = REG_BITS / 8,
  localparam int LEN_W    = $clog2(NBYTES) + 1,
  localparam int SUM_BITS = 8 << ((1 << CODE_W) - 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [CODE_W-1:0]   width_i,
  input  logic [LEN_W-1:0]    vlen_i,
  input  logic [REG_BITS-1:0] vec_i,
  output logic [SUM_BITS-1:0] sum_o,
  output logic                done_o
);
  import vred_pkg::*;

  logic [LEN_W-1:0]    vl_eff, len_pow, len_q;
  logic [CODE_W-1:0]   wcode_q;
  logic                run_q;
  logic [REG_BITS-1:0] work_q, masked, folded;
  logic [SUM_BITS-1:0] res_mask;

  vred_len #(.REG_BITS(REG_BITS), .CODE_W(CODE_W)) u_len (
    .code_i(width_i), .vlen_i(vlen_i), .vl_eff_o(vl_eff), .len_pow_o(len_pow)
  );

  // zero padding of lanes past the effective count
  for (genvar b = 0; b < NBYTES; b++) begin : g_pad
    logic [LEN_W-1:0] idx;
    assign idx = LEN_W'(b) >> width_i;
    assign masked[b*8 +: 8] = (idx < vl_eff) ? vec_i[b*8 +: 8] : 8'd0;
  end

  vred_fold #(.REG_BITS(REG_BITS), .CODE_W(CODE_W)) u_fold (
    .work_i(work_q), .code_i(wcode_q), .half_i(len_q >> 1), .fold_o(folded)
  );

  assign res_mask = ~({SUM_BITS{1'b1}} << elem_bits(32'(wcode_q)));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      len_q   <= LEN_W'(1);
      wcode_q <= '0;
      work_q  <= '0;
      sum_o   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!run_q) begin
        if (start_i) begin
          work_q  <= masked;
          len_q   <= len_pow;
          wcode_q <= width_i;
          run_q   <= 1'b1;
        end
      end else if (len_q <= LEN_W'(1)) begin
        sum_o  <= work_q[SUM_BITS-1:0] & res_mask;
        done_o <= 1'b1;
        run_q  <= 1'b0;
      end else begin
        work_q <= folded;
        len_q  <= len_q >> 1;
      end
    end
  end

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_sum_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(sum_o));
  assert_len_pow2_R7: assert property (@(posedge clk) disable iff (rst)
    run_q |-> $countones(len_q) == 1);
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
    (run_q && len_q > LEN_W'(1)) |=> (run_q && $stable(wcode_q)));
  assert_done_after_run_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(run_q));
  assert_width_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (sum_o & ~res_mask) == '0);
endmodule

// File: tb/vred_halving_top_tb.sv
module vred_halving_top_tb;
  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [1:0]    width_i = '0;
  logic [8:0]    vlen_i = '0;
  logic [2047:0] vec_i = '0;
  logic [63:0]   sum_o;
  logic          done_o;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  vred_halving_top u_dut (.clk(clk), .rst(rst), .start_i(start_i), .width_i(width_i),
    .vlen_i(vlen_i), .vec_i(vec_i), .sum_o(sum_o), .done_o(done_o));

  always #2.5 clk = ~clk;

  function automatic int eff_len(input int w, input int vl);
    int mvl = 256 >> w;
    return (vl > mvl) ? mvl : vl;
  endfunction

  function automatic logic [63:0] exp_sum(input int w, input int vl, input logic [2047:0] v);
    int ew = 8 << w;
    int n = eff_len(w, vl);
    logic [63:0] m = ~(64'hFFFF_FFFF_FFFF_FFFF << ew);
    logic [63:0] acc = 0;
    for (int i = 0; i < n; i++) acc = acc + (64'(v >> (i * ew)) & m);
    return acc & m;
  endfunction

  function automatic int exp_steps(input int w, input int vl);
    int n = eff_len(w, vl);
    int s = 0;
    while ((1 << s) < n) s++;
    return s;
  endfunction

  function automatic logic [2047:0] rand_vec();
    logic [2047:0] v;
    for (int i = 0; i < 64; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // busy_at: falling-edge count at which a stray start is pulsed (0 = none)
  task automatic run_op(input int w, input int vl, input logic [2047:0] v,
                        input int busy_at, input bit scramble, input string tag);
    int cnt;
    int s = exp_steps(w, vl);
    logic [63:0] e = exp_sum(w, vl, v);
    @(negedge clk);
    start_i = 1'b1; width_i = 2'(w); vlen_i = 9'(vl); vec_i = v;
    @(negedge clk);
    start_i = 1'b0;
    cnt = 1;
    if (scramble) begin
      width_i = ~2'(w); vlen_i = 9'd3; vec_i = rand_vec();
    end
    while (!done_o && cnt < 40) begin
      if (cnt == busy_at) begin
        start_i = 1'b1; width_i = 2'd3; vlen_i = 9'd1; vec_i = rand_vec();
      end
      @(negedge clk);
      start_i = 1'b0;
      cnt++;
    end
    check(done_o == 1'b1 && cnt == s + 2, {"R7 latency ", tag}, 64'(cnt), 64'(s + 2));
    check(sum_o == e, {"R3 sum ", tag}, sum_o, e);
    @(negedge clk);
    check(done_o == 1'b0, {"R8 pulse width ", tag}, 64'(done_o), 64'd0);
    if (busy_at != 0) begin
      bit extra = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (done_o) extra = 1;
      end
      check(!extra && sum_o == e, {"R9 stray start ignored ", tag}, sum_o, e);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2047:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(sum_o == 0 && done_o == 0, "R1 reset state", sum_o, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(sum_o == 0 && done_o == 0, "R1 after reset", sum_o, 64'd0);

    // R2 / R3: all-ones bytes wrap at 8 bits: 256*255 mod 256 = 0
    v = {2048{1'b1}};
    run_op(0, 256, v, 0, 0, "R2 8b full wrap");
    run_op(3, 32, v, 0, 0, "R2 64b full");
    // R6: zero length
    run_op(1, 0, v, 0, 0, "R6 zero length");
    // single element, zero fold steps
    run_op(2, 1, v, 0, 0, "R6 one element");
    // R4: garbage beyond the count is ignored; non power of two padding
    v = rand_vec();
    run_op(0, 5, v, 0, 0, "R4 padding len5");
    run_op(1, 100, v, 0, 0, "R4 padding len100");
    // R5: clamping
    run_op(3, 300, v, 0, 0, "R5 clamp 64b");
    run_op(2, 511, v, 0, 0, "R5 clamp 32b");
    // R9: start while busy
    run_op(0, 256, v, 3, 0, "R9 busy start");
    // R10: inputs change after capture
    run_op(1, 77, v, 0, 1, "R10 scrambled inputs");
    // R8: result holds over idle cycles
    repeat (10) @(negedge clk);
    check(sum_o == exp_sum(1, 77, v) && !done_o, "R8 hold", sum_o, exp_sum(1, 77, v));

    for (int it = 0; it < 40; it++) begin
      int w = $urandom % 4;
      int vl = $urandom % ((256 >> w) + 20);
      run_op(w, vl, rand_vec(), 0, it[0], "random");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule